// File: doc/BRIEF.md
# Parallel Flash Programming Controller

This block is the front end that a small microcontroller presents to an external programmer when it is placed in parallel programming mode. The programmer drives a four-bit mode code, a 14-bit address and an 8-bit data bus, and pulses an active-low program strobe. The block decodes the mode code into an operation on one of several stores and applies the operation when the strobe returns high. The stores are a byte-wide program memory, an encryption array, a three-level lock-bit register and an option register. The block can also return fixed identification bytes.

Writes and erases are accepted only if the strobe's low time meets a cycle-count rule. Byte writes must be short and erases must be long. A pulse that breaks its rule is dropped and flags an error. Read codes are used with the strobe held high. They drive registered read data and an output enable that tells the pad logic to turn the data bus around.

The flash array is a behavioural register array with a parameterised depth, and higher addresses alias onto it. The nominal strobe limits are 100 ms maximum for a write and 828 ms minimum for an erase. They are scaled to clock-cycle parameters.

Top module: `flash_prog_ctrl`

## Requirements
- R1: After reset `dout_o` is 00h and `dout_oe_o` and `err_o` are 0. Every program byte, every encryption byte and the lock register are erased to 1s, and the option register holds F7h.
- R2: `mode_i[3:0]` is decoded as follows (bit 3 first, 1 = high). 1000 mass erase. 0111 write program. 0011 read program. 0101 write encryption. 0001 read lock. 0100 write option. 1001 erase option. 0000 read ID/option. 1111 write lock level 1. 1100 write lock level 2. 1010 write lock level 3. Every other code is no operation and never enables the output.
- R3: A write-program pulse whose low time is 1 to SHORT_MAX_CYC clock cycles stores `din_i` at the addressed byte (address modulo PROG_DEPTH).
- R4: A mass-erase pulse of at least LONG_MIN_CYC cycles sets every program byte and every encryption byte to FFh and the lock register to 111b. It leaves the option register unchanged.
- R5: Lock writes are cumulative on {LB3,LB2,LB1}. Level 1 clears LB1, level 2 clears LB2 and LB1, and level 3 clears all three. A lock read at address 40h returns {5'b0,LB3,LB2,LB1}, and at any other address it returns 00h.
- R6: A lock bit returns to 1 only through an accepted mass erase.
- R7: A write-encryption pulse (short rule) stores `din_i` at address modulo ENC_DEPTH. A program read returns the stored byte XNOR the encryption byte at the read address modulo ENC_DEPTH.
- R8: A write-option pulse (short rule) stores `din_i`, whose bit 3 is the watchdog power-on default. An erase-option pulse (long rule) sets F7h, with the watchdog default cleared. An ID read at FCh returns the option register.
- R9: A pulse that breaks its width rule, or a pulse under a read code or an unused code, changes no store. At every strobe rising edge `err_o` is set to 1 if the pulse was dropped and to 0 if it was accepted.
- R10: An ID read returns MFG_ID at 30h, DEV_ID at 31h, DEV_EXT at 60h and 00h at any other address except FCh.
- R11: `dout_o` and `dout_oe_o` are registered. One clock edge after a read code is presented with the strobe high, `dout_oe_o` is 1 and `dout_o` holds the read value. Otherwise `dout_oe_o` is 0 and `dout_o` is 00h.
- R12: An operation uses the mode, address and data sampled at the last clock edge at which the strobe was low. A read captured at the commit edge returns the content before the commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 4 | Operation select code |
| strobe_n_i | input | 1 | Active-low program strobe, idles high |
| addr_i | input | ADDR_W | Byte address |
| din_i | input | 8 | Write data |
| dout_o | output | 8 | Registered read data, 00h when not reading |
| dout_oe_o | output | 1 | Read data output enable |
| err_o | output | 1 | Last strobe pulse was dropped |

## Verification
A commit of a write and a read capture can fall on the same clock edge. This happens when the programmer raises the strobe and, in the same cycle, switches the mode pins to a read of the byte just written. The bench provokes this with a write-program pulse whose rising edge coincides with the switch to a program read at the same address. The capture at that edge must show the erased old byte with the output enabled, and the next capture must show the new byte. This shows that the commit used the values latched while the strobe was low, and that the read path did not bypass the store.

// File: rtl/flash_prog_pkg.sv
// Shared operation and pulse-rule types for the parallel programming front end.
// Assumes a four-bit mode code with bit 3 as the first select pin.
package flash_prog_pkg;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_MASS_ERASE,
        OP_WR_PROG,
        OP_RD_PROG,
        OP_WR_ENC,
        OP_RD_LOCK,
        OP_WR_OPT,
        OP_ER_OPT,
        OP_RD_ID,
        OP_WR_LB1,
        OP_WR_LB2,
        OP_WR_LB3
    } op_e;

    typedef enum logic [1:0] {
        RULE_NONE,
        RULE_SHORT,
        RULE_LONG
    } rule_e;

    // Translate a mode code into an operation.
    function automatic op_e decode_mode(input logic [3:0] m);
        case (m)
            4'b1000: return OP_MASS_ERASE;
            4'b0111: return OP_WR_PROG;
            4'b0011: return OP_RD_PROG;
            4'b0101: return OP_WR_ENC;
            4'b0001: return OP_RD_LOCK;
            4'b0100: return OP_WR_OPT;
            4'b1001: return OP_ER_OPT;
            4'b0000: return OP_RD_ID;
            4'b1111: return OP_WR_LB1;
            4'b1100: return OP_WR_LB2;
            4'b1010: return OP_WR_LB3;
            default: return OP_NONE;
        endcase
    endfunction

    // Width rule that a strobe pulse must meet for an operation.
    function automatic rule_e rule_of(input op_e op);
        case (op)
            OP_MASS_ERASE, OP_ER_OPT:                 return RULE_LONG;
            OP_WR_PROG, OP_WR_ENC, OP_WR_OPT,
            OP_WR_LB1, OP_WR_LB2, OP_WR_LB3:          return RULE_SHORT;
            default:                                  return RULE_NONE;
        endcase
    endfunction

    // True for operations that drive the data bus.
    function automatic logic is_read_op(input op_e op);
        return (op == OP_RD_PROG) || (op == OP_RD_LOCK) || (op == OP_RD_ID);
    endfunction

endpackage

// File: rtl/fpc_mode_decode.sv
// Combinational decoder from the mode pins to an operation, its width rule
// and whether it is a read. Assumes the pins are already synchronous to clk.
module fpc_mode_decode
    import flash_prog_pkg::*;
(
    input  logic [3:0] mode_i,
    output op_e        op_o,
    output logic       is_read_o
);

    // Decode the pins once; the read flag follows from the operation.
    always_comb begin
        op_o      = decode_mode(mode_i);
        is_read_o = is_read_op(op_o);
    end

endmodule

// File: rtl/fpc_strobe_timer.sv
// Counts the clock edges at which the program strobe is sampled low, and on
// the strobe's rising edge judges the pulse against the rule of the latched
// operation. Assumes strobe_n_i is synchronous; the count saturates at a cap
// that keeps both rules exact.
module fpc_strobe_timer
    import flash_prog_pkg::*;
#(
    parameter int SHORT_MAX_CYC = 8,
    parameter int LONG_MIN_CYC  = 20
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  strobe_n_i,
    input  rule_e rule_i,
    output logic  accept_o,
    output logic  reject_o
);

    localparam int CAP   = (LONG_MIN_CYC > SHORT_MAX_CYC) ? LONG_MIN_CYC : SHORT_MAX_CYC + 1;
    localparam int CNT_W = $clog2(CAP + 1);
    localparam logic [CNT_W-1:0] CAP_V   = CNT_W'(CAP);
    localparam logic [CNT_W-1:0] SHORT_V = CNT_W'(SHORT_MAX_CYC);
    localparam logic [CNT_W-1:0] LONG_V  = CNT_W'(LONG_MIN_CYC);

    logic             low_q;
    logic [CNT_W-1:0] cnt_q;
    logic             rise;
    logic             width_ok;

    // Track the previous strobe level and count low samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_q <= 1'b0;
            cnt_q <= '0;
        end else begin
            low_q <= !strobe_n_i;
            if (!strobe_n_i) begin
                if (cnt_q != CAP_V) cnt_q <= cnt_q + 1'b1;
            end else begin
                cnt_q <= '0;
            end
        end
    end

    // Judge the finished pulse at the rising edge.
    always_comb begin
        rise = strobe_n_i && low_q;
        case (rule_i)
            RULE_SHORT: width_ok = (cnt_q <= SHORT_V);
            RULE_LONG:  width_ok = (cnt_q >= LONG_V);
            default:    width_ok = 1'b0;
        endcase
        accept_o = rise && width_ok;
        reject_o = rise && !width_ok;
    end

endmodule

// File: rtl/fpc_store.sv
// Behavioural flash contents: program bytes, encryption bytes, lock levels and
// option register, with the read multiplexer for all read codes. Writes occur
// on wr_en; reads are combinational from current state, so a read in the
// commit cycle sees the old content. Assumes ENC_DEPTH <= PROG_DEPTH.
module fpc_store
    import flash_prog_pkg::*;
#(
    parameter int         ADDR_W     = 14,
    parameter int         PROG_DEPTH = 256,
    parameter int         ENC_DEPTH  = 64,
    parameter logic [7:0] MFG_ID     = 8'hDA,
    parameter logic [7:0] DEV_ID     = 8'h4B,
    parameter logic [7:0] DEV_EXT    = 8'h01,
    parameter logic [7:0] OPT_ERASED = 8'hF7,
    localparam int        PROG_AW    = $clog2(PROG_DEPTH),
    localparam int        ENC_AW     = $clog2(ENC_DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en_i,
    input  op_e                wr_op_i,
    input  logic [PROG_AW-1:0] wr_addr_i,
    input  logic [7:0]         wr_data_i,
    input  op_e                rd_op_i,
    input  logic [ADDR_W-1:0]  rd_addr_i,
    output logic [7:0]         rd_data_o,
    output logic [2:0]         lock_o
);

    localparam logic [ADDR_W-1:0] A_LOCK = ADDR_W'('h40);
    localparam logic [ADDR_W-1:0] A_MFG  = ADDR_W'('h30);
    localparam logic [ADDR_W-1:0] A_DEV  = ADDR_W'('h31);
    localparam logic [ADDR_W-1:0] A_EXT  = ADDR_W'('h60);
    localparam logic [ADDR_W-1:0] A_OPT  = ADDR_W'('hFC);

    logic [7:0] prog_mem [PROG_DEPTH];
    logic [7:0] enc_mem  [ENC_DEPTH];
    logic [2:0] lock_q;
    logic [7:0] opt_q;

    // Program memory: byte write or full erase.
    always_ff @(posedge clk) begin
        if (!rst_n || (wr_en_i && wr_op_i == OP_MASS_ERASE)) begin
            for (int i = 0; i < PROG_DEPTH; i++) prog_mem[i] <= 8'hFF;
        end else if (wr_en_i && wr_op_i == OP_WR_PROG) begin
            prog_mem[wr_addr_i] <= wr_data_i;
        end
    end

    // Encryption array: byte write or full erase.
    always_ff @(posedge clk) begin
        if (!rst_n || (wr_en_i && wr_op_i == OP_MASS_ERASE)) begin
            for (int i = 0; i < ENC_DEPTH; i++) enc_mem[i] <= 8'hFF;
        end else if (wr_en_i && wr_op_i == OP_WR_ENC) begin
            enc_mem[wr_addr_i[ENC_AW-1:0]] <= wr_data_i;
        end
    end

    // Lock levels (cumulative clears) and option register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q <= 3'b111;
            opt_q  <= OPT_ERASED;
        end else if (wr_en_i) begin
            case (wr_op_i)
                OP_MASS_ERASE: lock_q <= 3'b111;
                OP_WR_LB1:     lock_q <= lock_q & 3'b110;
                OP_WR_LB2:     lock_q <= lock_q & 3'b100;
                OP_WR_LB3:     lock_q <= 3'b000;
                OP_WR_OPT:     opt_q  <= wr_data_i;
                OP_ER_OPT:     opt_q  <= OPT_ERASED;
                default:       ;
            endcase
        end
    end

    // Read multiplexer for the three read codes.
    always_comb begin
        rd_data_o = 8'h00;
        case (rd_op_i)
            OP_RD_PROG: rd_data_o = ~(prog_mem[rd_addr_i[PROG_AW-1:0]]
                                      ^ enc_mem[rd_addr_i[ENC_AW-1:0]]);
            OP_RD_LOCK: if (rd_addr_i == A_LOCK) rd_data_o = {5'b00000, lock_q};
            OP_RD_ID: begin
                if      (rd_addr_i == A_MFG) rd_data_o = MFG_ID;
                else if (rd_addr_i == A_DEV) rd_data_o = DEV_ID;
                else if (rd_addr_i == A_EXT) rd_data_o = DEV_EXT;
                else if (rd_addr_i == A_OPT) rd_data_o = opt_q;
            end
            default: ;
        endcase
    end

    assign lock_o = lock_q;

endmodule

// File: rtl/flash_prog_ctrl.sv
// Top of the parallel programming front end. Decodes the mode pins, latches
// mode/address/data at every edge the strobe is low, commits at the strobe's
// rising edge when the width rule holds, and registers read data, output
// enable and the error flag. Assumes all pins are synchronous to clk.
module flash_prog_ctrl
    import flash_prog_pkg::*;
#(
    parameter int         ADDR_W        = 14,
    parameter int         PROG_DEPTH    = 256,
    parameter int         ENC_DEPTH     = 64,
    parameter int         SHORT_MAX_CYC = 8,
    parameter int         LONG_MIN_CYC  = 20,
    parameter logic [7:0] MFG_ID        = 8'hDA,
    parameter logic [7:0] DEV_ID        = 8'h4B,
    parameter logic [7:0] DEV_EXT       = 8'h01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        mode_i,
    input  logic              strobe_n_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        din_i,
    output logic [7:0]        dout_o,
    output logic              dout_oe_o,
    output logic              err_o
);

    localparam int PROG_AW = $clog2(PROG_DEPTH);

    op_e                op_pin;
    logic               rd_pin;
    op_e                op_l;
    logic [PROG_AW-1:0] addr_l;
    logic [7:0]         din_l;
    logic               accept_w;
    logic               reject_w;
    logic [7:0]         rd_data_w;
    logic [2:0]         lock_w;
    logic [7:0]         dout_q;
    logic               oe_q;
    logic               err_q;

    fpc_mode_decode u_dec (
        .mode_i    (mode_i),
        .op_o      (op_pin),
        .is_read_o (rd_pin)
    );

    // Hold the operation as seen at the last low-strobe edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_l   <= OP_NONE;
            addr_l <= '0;
            din_l  <= '0;
        end else if (!strobe_n_i) begin
            op_l   <= op_pin;
            addr_l <= addr_i[PROG_AW-1:0];
            din_l  <= din_i;
        end
    end

    fpc_strobe_timer #(
        .SHORT_MAX_CYC (SHORT_MAX_CYC),
        .LONG_MIN_CYC  (LONG_MIN_CYC)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe_n_i (strobe_n_i),
        .rule_i     (rule_of(op_l)),
        .accept_o   (accept_w),
        .reject_o   (reject_w)
    );

    fpc_store #(
        .ADDR_W     (ADDR_W),
        .PROG_DEPTH (PROG_DEPTH),
        .ENC_DEPTH  (ENC_DEPTH),
        .MFG_ID     (MFG_ID),
        .DEV_ID     (DEV_ID),
        .DEV_EXT    (DEV_EXT)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (accept_w),
        .wr_op_i   (op_l),
        .wr_addr_i (addr_l),
        .wr_data_i (din_l),
        .rd_op_i   (op_pin),
        .rd_addr_i (addr_i),
        .rd_data_o (rd_data_w),
        .lock_o    (lock_w)
    );

    // Register the bus outputs and the verdict of each finished pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_q <= 8'h00;
            oe_q   <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            oe_q   <= rd_pin && strobe_n_i;
            dout_q <= (rd_pin && strobe_n_i) ? rd_data_w : 8'h00;
            if (accept_w || reject_w) err_q <= reject_w;
        end
    end

    assign dout_o    = dout_q;
    assign dout_oe_o = oe_q;
    assign err_o     = err_q;

endmodule

// File: rtl/flash_prog_ctrl_chk.sv
// Property checker for flash_prog_ctrl, attached by bind below.
module flash_prog_ctrl_chk
    import flash_prog_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] mode_i,
    input logic       strobe_n_i,
    input logic [7:0] dout_o,
    input logic       dout_oe_o,
    input logic       err_o,
    input logic [2:0] lock_bits,
    input logic       accept,
    input op_e        op_l
);

    // R11: output enable only follows a read code with the strobe high
    a_r11_oe_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        dout_oe_o |-> ($past(strobe_n_i) &&
                       ($past(mode_i) == 4'b0011 || $past(mode_i) == 4'b0001 ||
                        $past(mode_i) == 4'b0000)));

    // R5: a lock read has zeros above the three lock bits
    a_r5_lock_read_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_oe_o && $past(mode_i) == 4'b0001) |-> (dout_o[7:3] == 5'b00000));

    // R6: a lock bit goes back to 1 only after an accepted mass erase
    a_r6_lock_only_erase_restores: assert property (@(posedge clk) disable iff (!rst_n)
        (|(lock_bits & ~$past(lock_bits))) |-> ($past(accept) && $past(op_l) == OP_MASS_ERASE));

    // R9: the error flag rises only at a strobe rising edge
    a_r9_err_at_strobe_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> ($past(strobe_n_i) && !$past(strobe_n_i, 2)));

endmodule

bind flash_prog_ctrl flash_prog_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_i     (mode_i),
    .strobe_n_i (strobe_n_i),
    .dout_o     (dout_o),
    .dout_oe_o  (dout_oe_o),
    .err_o      (err_o),
    .lock_bits  (lock_w),
    .accept     (accept_w),
    .op_l       (op_l)
);

// File: tb/test_flash_prog_ctrl.sv
`timescale 1ns/100ps
module test_flash_prog_ctrl;

    localparam logic [3:0] ME = 4'b1000, WP = 4'b0111, RP = 4'b0011, WE = 4'b0101;
    localparam logic [3:0] RL = 4'b0001, WO = 4'b0100, EO = 4'b1001, RI = 4'b0000;
    localparam logic [3:0] L1 = 4'b1111, L2 = 4'b1100, L3 = 4'b1010, XX = 4'b0010;

    typedef struct packed {
        logic [3:0]  mode;
        logic [13:0] addr;
        logic [7:0]  din;
        logic [7:0]  width;
        logic        exp_err;
        logic [3:0]  rmode;
        logic [13:0] raddr;
        logic [7:0]  exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VEC [NV] = '{
        '{WP, 14'h12, 8'h3C, 8'd3,  1'b0, RP, 14'h12, 8'h3C, 8'd3},  // R3
        '{WP, 14'h13, 8'h00, 8'd8,  1'b0, RP, 14'h13, 8'h00, 8'd3},  // R3 at max width
        '{WP, 14'h14, 8'h55, 8'd9,  1'b1, RP, 14'h14, 8'hFF, 8'd9},  // R9 too long
        '{WP, 14'h14, 8'h55, 8'd1,  1'b0, RP, 14'h14, 8'h55, 8'd9},  // R9 clears, R3
        '{WP, 14'h114,8'hAA, 8'd2,  1'b0, RP, 14'h14, 8'hAA, 8'd3},  // R3 aliasing
        '{WE, 14'h12, 8'h0F, 8'd2,  1'b0, RP, 14'h12, 8'hCC, 8'd7},  // R7
        '{RP, 14'h00, 8'h00, 8'd0,  1'b0, RP, 14'h52, 8'h0F, 8'd7},  // R7 enc aliasing
        '{L1, 14'h00, 8'h00, 8'd2,  1'b0, RL, 14'h40, 8'h06, 8'd5},  // R5
        '{RL, 14'h00, 8'h00, 8'd0,  1'b0, RL, 14'h41, 8'h00, 8'd5},  // R5 wrong addr
        '{L3, 14'h00, 8'h00, 8'd20, 1'b1, RL, 14'h40, 8'h06, 8'd9},  // R9
        '{L2, 14'h00, 8'h00, 8'd4,  1'b0, RL, 14'h40, 8'h04, 8'd5},  // R5
        '{L1, 14'h00, 8'h00, 8'd4,  1'b0, RL, 14'h40, 8'h04, 8'd6},  // R6
        '{WO, 14'h00, 8'h08, 8'd5,  1'b0, RI, 14'hFC, 8'h08, 8'd8},  // R8
        '{EO, 14'h00, 8'h00, 8'd19, 1'b1, RI, 14'hFC, 8'h08, 8'd9},  // R9
        '{EO, 14'h00, 8'h00, 8'd20, 1'b0, RI, 14'hFC, 8'hF7, 8'd8},  // R8
        '{RI, 14'h00, 8'h00, 8'd0,  1'b0, RI, 14'h30, 8'hDA, 8'd10}, // R10
        '{RI, 14'h00, 8'h00, 8'd0,  1'b0, RI, 14'h31, 8'h4B, 8'd10}, // R10
        '{RI, 14'h00, 8'h00, 8'd0,  1'b0, RI, 14'h60, 8'h01, 8'd10}, // R10
        '{RI, 14'h00, 8'h00, 8'd0,  1'b0, RI, 14'h61, 8'h00, 8'd10}, // R10
        '{ME, 14'h00, 8'h00, 8'd19, 1'b1, RP, 14'h13, 8'h00, 8'd9},  // R9
        '{ME, 14'h00, 8'h00, 8'd25, 1'b0, RP, 14'h13, 8'hFF, 8'd4},  // R4
        '{RP, 14'h00, 8'h00, 8'd0,  1'b0, RP, 14'h12, 8'hFF, 8'd4},  // R4 enc erased
        '{RL, 14'h00, 8'h00, 8'd0,  1'b0, RL, 14'h40, 8'h07, 8'd4},  // R4 lock erased
        '{RI, 14'h00, 8'h00, 8'd0,  1'b0, RI, 14'hFC, 8'hF7, 8'd4},  // R4 option kept
        '{L3, 14'h00, 8'h00, 8'd3,  1'b0, RL, 14'h40, 8'h00, 8'd5},  // R5
        '{RP, 14'h12, 8'h77, 8'd3,  1'b1, RP, 14'h12, 8'hFF, 8'd9}   // R9 pulse under read
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  mode_i = XX;
    logic        strobe_n_i = 1'b1;
    logic [13:0] addr_i = '0;
    logic [7:0]  din_i = '0;
    logic [7:0]  dout_o;
    logic        dout_oe_o;
    logic        err_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    flash_prog_ctrl i_flash_prog_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (mode_i),
        .strobe_n_i (strobe_n_i),
        .addr_i     (addr_i),
        .din_i      (din_i),
        .dout_o     (dout_o),
        .dout_oe_o  (dout_oe_o),
        .err_o      (err_o)
    );

    task automatic chk(input int req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Strobe low for 'width' sampled edges, then raise; returns after commit edge.
    task automatic pulse(input logic [3:0] m, input logic [13:0] a, input logic [7:0] d, input int width);
        @(negedge clk);
        mode_i = m; addr_i = a; din_i = d; strobe_n_i = 1'b0;
        repeat (width) @(posedge clk);
        @(negedge clk);
        strobe_n_i = 1'b1;
        @(posedge clk);
    endtask

    task automatic rd(input logic [3:0] m, input logic [13:0] a);
        @(negedge clk);
        mode_i = m; addr_i = a; strobe_n_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk(1, "oe after reset", {7'b0, dout_oe_o}, 8'h00);
        chk(1, "dout after reset", dout_o, 8'h00);
        chk(1, "err after reset", {7'b0, err_o}, 8'h00);
        rd(RP, 14'h00);
        chk(1, "erased program byte", dout_o, 8'hFF);
        rd(RL, 14'h40);
        chk(1, "erased lock bits", dout_o, 8'h07);
        rd(RI, 14'hFC);
        chk(1, "option reset value", dout_o, 8'hF7);

        // Table walk: R2 decode exercised through every code below
        for (int i = 0; i < NV; i++) begin
            if (VEC[i].width != 0) begin
                pulse(VEC[i].mode, VEC[i].addr, VEC[i].din, int'(VEC[i].width));
                @(negedge clk);
                chk(int'(VEC[i].req), $sformatf("vec %0d err", i), {7'b0, err_o}, {7'b0, VEC[i].exp_err});
            end
            rd(VEC[i].rmode, VEC[i].raddr);
            chk(int'(VEC[i].req), $sformatf("vec %0d data", i), dout_o, VEC[i].exp);
            chk(11, $sformatf("vec %0d oe", i), {7'b0, dout_oe_o}, 8'h01);
        end

        // R2/R9: pulse under an unused code is dropped with error
        pulse(XX, 14'h12, 8'h00, 3);
        @(negedge clk);
        chk(9, "unused code err", {7'b0, err_o}, 8'h01);
        chk(2, "unused code no oe", {7'b0, dout_oe_o}, 8'h00);
        rd(4'b0110, 14'h30);
        chk(2, "unused code oe", {7'b0, dout_oe_o}, 8'h00);
        chk(11, "dout idle when not reading", dout_o, 8'h00);

        // R11: one-edge latency of output enable
        rd(WP, 14'h12);
        chk(11, "oe under write code", {7'b0, dout_oe_o}, 8'h00);
        @(negedge clk);
        mode_i = RP; addr_i = 14'h12;
        #1;
        chk(11, "oe before edge", {7'b0, dout_oe_o}, 8'h00);
        @(negedge clk);
        chk(11, "oe after edge", {7'b0, dout_oe_o}, 8'h01);

        // R12: commit and read capture on the same edge
        @(negedge clk);
        mode_i = WP; addr_i = 14'h20; din_i = 8'hA1; strobe_n_i = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        strobe_n_i = 1'b1; mode_i = RP; din_i = 8'h00;
        @(posedge clk);
        @(negedge clk);
        chk(12, "read at commit edge old byte", dout_o, 8'hFF);
        chk(12, "oe at commit edge", {7'b0, dout_oe_o}, 8'h01);
        chk(12, "commit accepted", {7'b0, err_o}, 8'h00);
        @(negedge clk);
        chk(12, "read after commit new byte", dout_o, 8'hA1);

        // R12: mode switched mid-pulse, last low sample wins
        @(negedge clk);
        mode_i = L1; strobe_n_i = 1'b0;
        @(posedge clk);
        @(negedge clk);
        mode_i = WP; addr_i = 14'h21; din_i = 8'h5A;
        @(posedge clk);
        @(negedge clk);
        strobe_n_i = 1'b1;
        @(posedge clk);
        rd(RP, 14'h21);
        chk(12, "last low sample used", dout_o, 8'h5A);
        rd(RL, 14'h40);
        chk(12, "earlier mode ignored", dout_o, 8'h00);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R0 watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule